// File: doc/BRIEF.md
# Character LCD Interface Sequencer

This block connects a host to a small two-line character display controller over a parallel bus. The bus has an 8-bit data path and three control lines: register select, read/write and an enable strobe. After reset the block waits out a power-up delay and then sends a fixed initialization sequence to the display. Once that sequence is done, it accepts instruction or character words from a valid/ready host port and writes each one to the display.

The display reports through a busy flag on data line 7, which it drives while it is still working on an earlier command. Before every write, the block reads that flag back and keeps reading until the flag is clear.

A parameter selects the bus width. In 8-bit mode each byte is one bus cycle. In 4-bit mode each byte is two bus cycles on data lines 7..4, and each busy read also takes two cycles. The initialization sequence in 4-bit mode starts with a single-nibble command that switches the display out of its power-on 8-bit width. All strobe and setup/hold timings are counted in clock cycles and are set by parameters.

Top module: `lcd_seq_top`

## Requirements
- R1: While reset is held, and for POWERUP_CYCLES clock cycles after reset is released, enable and register select stay low and hostReady stays low.
- R2: Initialization writes the following bytes in this order, each with register select 0. In 4-bit mode it first writes a single 4-bit transfer of 0x2 on lines 7..4. Then comes the width/lines/font setup byte: 0x20 in 4-bit mode or 0x30 in 8-bit mode, with bit 3 = two lines and bit 2 = tall font. Next is the display control byte 0x08, with bit 2 = display on, bit 1 = cursor on and bit 0 = blink. Last is the clear byte 0x01.
- R3: A host word is 9 bits. Bit 8 is the register-select value (0 = instruction, 1 = character data) and bits 7..0 are the byte. Every accepted word is written exactly once, in the order accepted, with register select equal to bit 8.
- R4: Writes drive read/write = 0 with the data bus driven (lcdDataOe = 1). Busy reads drive read/write = 1 and register select = 0, with the bus released (lcdDataOe = 0).
- R5: Every write is preceded by busy reads. The block samples data line 7 and repeats the read until it returns 0. No write starts while the display is busy.
- R6: In 4-bit mode, each byte goes out as two enable pulses: the upper nibble first, then the lower nibble, both on lines 7..4, with lines 3..0 driven to 0. A busy read also takes two pulses, and the flag is taken from the first one. In 8-bit mode every transfer is a single pulse.
- R7: Enable stays high for exactly EN_CYCLES cycles. Register select, read/write, bus enable and data are stable for at least SETUP_CYCLES cycles before enable rises, while it is high, and for HOLD_CYCLES cycles after it falls.
- R8: hostReady is high only when initialization is done and no transfer is in progress. It rises exactly HOLD_CYCLES cycles after the last enable pulse of a write ends, and it drops in the cycle after a word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostValid | input | 1 | Host word is offered |
| hostWord | input | 9 | Bit 8 register-select value, bits 7..0 byte |
| hostReady | output | 1 | Block can take a word |
| lcdDataIn | input | 8 | Data bus as driven by the display during reads |
| lcdDataOut | output | 8 | Data bus value driven by the block |
| lcdDataOe | output | 1 | Block drives the data bus |
| lcdRs | output | 1 | Register select (0 instruction, 1 data) |
| lcdRw | output | 1 | Read/write (1 read) |
| lcdEn | output | 1 | Enable strobe |

## Verification
The bench attacks these corner cases:
- **Busy-flag handling.** The display model keeps its busy flag set for a different length after each write. A design that sampled the flag at the wrong moment, or did not repeat the read, would write while the display is busy.
- **4-bit width switch.** The lone width-switch nibble is followed straight away by two-pulse transfers. A design that swapped the nibbles, sent two pulses for the switch, or read the busy flag in one pulse after the switch would put the display's nibble phase out of step, and the decoded bytes would be wrong.
- **Minimum timing.** A second instance runs 8-bit mode with one-cycle setup, strobe and hold. An off-by-one in any phase counter shows up there as a short pulse or a line that moves too early.
- **Early host word.** A host word is offered during initialization. It must wait, so that hostReady rising early or late is caught on every clock.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {
    ST_PWR,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_IDLE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadInit;
    logic       loadHost;
    logic       readMode;
    logic       secondNib;
    logic       enable;
    logic       sampleBusy;
    logic [7:0] initByte;
  } seqStrobe_t;

  // initialization byte for a given step; step 0 of 4-bit mode is the width switch
  function automatic logic [7:0] initCode(input logic [1:0] idx, input bit nib,
                                          input bit twoLine, input bit bigFont,
                                          input bit dispOn, input bit curOn,
                                          input bit blinkOn);
    logic [7:0] fset;
    logic [7:0] dctl;
    fset = {3'b001, ~nib, twoLine, bigFont, 2'b00};
    dctl = {5'b00001, dispOn, curOn, blinkOn};
    if (nib) begin
      case (idx)
        2'd0:    initCode = 8'h20;
        2'd1:    initCode = fset;
        2'd2:    initCode = dctl;
        default: initCode = 8'h01;
      endcase
    end else begin
      case (idx)
        2'd0:    initCode = fset;
        2'd1:    initCode = dctl;
        default: initCode = 8'h01;
      endcase
    end
  endfunction

endpackage

// File: rtl/lcd_seq_ctrl.sv
module lcd_seq_ctrl
  import lcd_seq_pkg::*;
#(
  parameter int NIBBLE_MODE    = 1,
  parameter int POWERUP_CYCLES = 32,
  parameter int SETUP_CYCLES   = 2,
  parameter int EN_CYCLES      = 4,
  parameter int HOLD_CYCLES    = 2,
  parameter int TWO_LINES      = 1,
  parameter int BIG_FONT       = 0,
  parameter int DISP_ON        = 1,
  parameter int CURSOR_ON      = 1,
  parameter int BLINK_ON       = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic       busyFlag,
  output logic       hostReady,
  output seqStrobe_t strobe
);

  localparam int MAX_A   = (POWERUP_CYCLES > SETUP_CYCLES) ? POWERUP_CYCLES : SETUP_CYCLES;
  localparam int MAX_B   = (EN_CYCLES > HOLD_CYCLES) ? EN_CYCLES : HOLD_CYCLES;
  localparam int MAX_ALL = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_ALL + 1);
  localparam logic [CNT_W-1:0] PWR_END  = CNT_W'(POWERUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] SET_END  = CNT_W'(SETUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] EN_END   = CNT_W'(EN_CYCLES - 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYCLES - 1);
  localparam logic [1:0] LAST_STEP = (NIBBLE_MODE != 0) ? 2'd3 : 2'd2;

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] phaseEnd;
  logic [1:0]       step;
  logic [1:0]       nextIdx;
  logic             reading;
  logic             second;
  logic             initDone;
  logic             lastCnt;
  logic             twoPulse;
  logic             accept;
  logic             pwrDone;
  logic             writeDone;

  always_comb begin
    case (state)
      ST_PWR:   phaseEnd = PWR_END;
      ST_SETUP: phaseEnd = SET_END;
      ST_PULSE: phaseEnd = EN_END;
      default:  phaseEnd = HOLD_END;
    endcase
  end

  assign lastCnt   = (cnt == phaseEnd);
  assign twoPulse  = (NIBBLE_MODE != 0) && (initDone || step != 2'd0);
  assign hostReady = (state == ST_IDLE);
  assign accept    = hostValid && hostReady;
  assign pwrDone   = (state == ST_PWR) && lastCnt;
  assign writeDone = (state == ST_HOLD) && lastCnt && !reading && (!twoPulse || second);
  assign nextIdx   = (state == ST_PWR) ? 2'd0 : step + 2'd1;

  always_comb begin
    strobe            = '0;
    strobe.readMode   = reading;
    strobe.secondNib  = second;
    strobe.enable     = (state == ST_PULSE);
    strobe.sampleBusy = (state == ST_PULSE) && lastCnt && reading && !second;
    strobe.loadHost   = accept;
    strobe.loadInit   = pwrDone || (writeDone && !initDone && step != LAST_STEP);
    strobe.initByte   = initCode(nextIdx, NIBBLE_MODE != 0, TWO_LINES != 0, BIG_FONT != 0,
                                 DISP_ON != 0, CURSOR_ON != 0, BLINK_ON != 0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PWR;
      cnt      <= '0;
      step     <= 2'd0;
      reading  <= 1'b0;
      second   <= 1'b0;
      initDone <= 1'b0;
    end else begin
      case (state)
        ST_PWR: begin
          if (lastCnt) begin
            cnt     <= '0;
            state   <= ST_SETUP;
            reading <= 1'b1;
            second  <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        ST_SETUP: begin
          if (lastCnt) begin
            cnt   <= '0;
            state <= ST_PULSE;
          end else cnt <= cnt + 1'b1;
        end
        ST_PULSE: begin
          if (lastCnt) begin
            cnt   <= '0;
            state <= ST_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        ST_HOLD: begin
          if (!lastCnt) cnt <= cnt + 1'b1;
          else begin
            cnt <= '0;
            if (twoPulse && !second) begin
              second <= 1'b1;
              state  <= ST_SETUP;
            end else begin
              second <= 1'b0;
              if (reading) begin
                reading <= busyFlag;       // poll again while busy
                state   <= ST_SETUP;
              end else if (!initDone && step != LAST_STEP) begin
                step    <= step + 2'd1;
                reading <= 1'b1;
                state   <= ST_SETUP;
              end else begin
                initDone <= 1'b1;
                state    <= ST_IDLE;
              end
            end
          end
        end
        default: begin
          if (accept) begin
            state   <= ST_SETUP;
            reading <= 1'b1;
            second  <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/lcd_seq_dp.sv
module lcd_seq_dp
  import lcd_seq_pkg::*;
#(
  parameter int NIBBLE_MODE = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic [8:0] hostWord,
  input  logic [7:0] lcdDataIn,
  output logic       busyFlag,
  output logic [7:0] lcdDataOut,
  output logic       lcdDataOe,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn
);

  logic [7:0] byteReg;
  logic       rsReg;
  logic       unusedSink;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteReg  <= 8'h00;
      rsReg    <= 1'b0;
      busyFlag <= 1'b0;
    end else begin
      if (strobe.loadInit) begin
        byteReg <= strobe.initByte;
        rsReg   <= 1'b0;
      end else if (strobe.loadHost) begin
        byteReg <= hostWord[7:0];
        rsReg   <= hostWord[8];
      end
      if (strobe.sampleBusy) busyFlag <= lcdDataIn[7];
    end
  end

  assign lcdRw      = strobe.readMode;
  assign lcdRs      = !strobe.readMode && rsReg;
  assign lcdEn      = strobe.enable;
  assign lcdDataOe  = !strobe.readMode;
  assign unusedSink = ^lcdDataIn[6:0] ^ strobe.secondNib;

  generate
    if (NIBBLE_MODE != 0) begin : g_nib
      always_comb begin
        if (strobe.readMode) lcdDataOut = 8'h00;
        else lcdDataOut = {strobe.secondNib ? byteReg[3:0] : byteReg[7:4], 4'h0};
      end
    end else begin : g_byte
      assign lcdDataOut = strobe.readMode ? 8'h00 : byteReg;
    end
  endgenerate

endmodule

// File: rtl/lcd_seq_top.sv
module lcd_seq_top
  import lcd_seq_pkg::*;
#(
  parameter int NIBBLE_MODE    = 1,
  parameter int POWERUP_CYCLES = 32,
  parameter int SETUP_CYCLES   = 2,
  parameter int EN_CYCLES      = 4,
  parameter int HOLD_CYCLES    = 2,
  parameter int TWO_LINES      = 1,
  parameter int BIG_FONT       = 0,
  parameter int DISP_ON        = 1,
  parameter int CURSOR_ON      = 1,
  parameter int BLINK_ON       = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic [8:0] hostWord,
  output logic       hostReady,
  input  logic [7:0] lcdDataIn,
  output logic [7:0] lcdDataOut,
  output logic       lcdDataOe,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdEn
);

  seqStrobe_t strobe;
  logic       busyFlag;

  lcd_seq_ctrl #(
    .NIBBLE_MODE(NIBBLE_MODE), .POWERUP_CYCLES(POWERUP_CYCLES),
    .SETUP_CYCLES(SETUP_CYCLES), .EN_CYCLES(EN_CYCLES), .HOLD_CYCLES(HOLD_CYCLES),
    .TWO_LINES(TWO_LINES), .BIG_FONT(BIG_FONT), .DISP_ON(DISP_ON),
    .CURSOR_ON(CURSOR_ON), .BLINK_ON(BLINK_ON)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hostValid(hostValid), .busyFlag(busyFlag),
    .hostReady(hostReady), .strobe(strobe)
  );

  lcd_seq_dp #(.NIBBLE_MODE(NIBBLE_MODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWord(hostWord),
    .lcdDataIn(lcdDataIn), .busyFlag(busyFlag), .lcdDataOut(lcdDataOut),
    .lcdDataOe(lcdDataOe), .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdEn(lcdEn)
  );

endmodule

// File: rtl/lcd_seq_chk.sv
module lcd_seq_chk #(
  parameter int NIBBLE_MODE    = 1,
  parameter int POWERUP_CYCLES = 32,
  parameter int EN_CYCLES      = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostValid,
  input logic       hostReady,
  input logic [7:0] lcdDataOut,
  input logic       lcdDataOe,
  input logic       lcdRs,
  input logic       lcdRw,
  input logic       lcdEn
);

  int enRun;
  int sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enRun    <= 0;
      sinceRst <= 0;
    end else begin
      enRun <= lcdEn ? enRun + 1 : 0;
      if (sinceRst < POWERUP_CYCLES) sinceRst <= sinceRst + 1;
    end
  end

  a_r1_quiet_startup: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < POWERUP_CYCLES) |-> (!lcdEn && !lcdRs && !hostReady));

  a_r4_poll_released: assert property (@(posedge clk) disable iff (!rstN)
    lcdRw |-> (!lcdRs && !lcdDataOe));

  a_r6_low_lines_zero: assert property (@(posedge clk) disable iff (!rstN)
    (NIBBLE_MODE != 0 && lcdDataOe) |-> (lcdDataOut[3:0] == 4'h0));

  a_r7_en_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lcdEn) |-> (enRun == EN_CYCLES));

  a_r7_stable_high: assert property (@(posedge clk) disable iff (!rstN)
    (lcdEn && $past(lcdEn)) |-> ($stable(lcdRs) && $stable(lcdRw) && $stable(lcdDataOut)));

  a_r8_ready_quiet: assert property (@(posedge clk) disable iff (!rstN)
    hostReady |-> !lcdEn);

  a_r8_take_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (hostValid && hostReady) |=> !hostReady);

endmodule

bind lcd_seq_top lcd_seq_chk #(
  .NIBBLE_MODE(NIBBLE_MODE), .POWERUP_CYCLES(POWERUP_CYCLES), .EN_CYCLES(EN_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .hostValid(hostValid), .hostReady(hostReady),
  .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe), .lcdRs(lcdRs),
  .lcdRw(lcdRw), .lcdEn(lcdEn)
);

// File: tb/lcd_disp_model.sv
module lcd_disp_model #(
  parameter int NIB = 1,
  parameter int SETUP = 2,
  parameter int EN = 3,
  parameter int HOLD = 2,
  parameter int POWERUP = 20,
  parameter int TWO = 1,
  parameter int BIG = 0,
  parameter int DON = 1,
  parameter int CON = 1,
  parameter int BON = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostValid,
  input  logic [8:0] hostWord,
  input  logic       hostReady,
  input  logic [7:0] lcdDataOut,
  input  logic       lcdDataOe,
  input  logic       lcdRs,
  input  logic       lcdRw,
  input  logic       lcdEn,
  output logic [7:0] lcdDataIn
);

  int nCmp = 0;
  int nBad = 0;
  logic [8:0] expQ[$];
  int initLeft = 0;
  int sinceRst = 0;
  int run = 0;
  int enHigh = 0;
  int holdLeft = 0;
  int busy = 0;
  int nWrites = 0;
  int readyCd = 0;
  bit prevEn = 0;
  bit wide = 1;
  bit phase = 0;
  bit drvBusy = 0;
  bit polledIdle = 0;
  logic [3:0] hiNib = 4'h0;
  logic [10:0] prevLines = '0;
  logic [10:0] lines;
  logic [7:0] got;
  logic [8:0] want;
  bit expReady;
  bit done;

  assign lcdDataIn = (lcdEn && lcdRw && (wide || !phase) && busy > 0) ? 8'h80 : 8'h00;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %m %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    logic [7:0] fset;
    fset = (NIB != 0) ? 8'h20 : 8'h30;
    if (TWO != 0) fset = fset | 8'h08;
    if (BIG != 0) fset = fset | 8'h04;
    if (NIB != 0) expQ.push_back(9'h020);
    expQ.push_back({1'b0, fset});
    expQ.push_back({1'b0, 8'h08 | ((DON != 0) ? 8'h04 : 8'h00) |
                    ((CON != 0) ? 8'h02 : 8'h00) | ((BON != 0) ? 8'h01 : 8'h00)});
    expQ.push_back(9'h001);
    initLeft = expQ.size();
  end

  always @(negedge clk) begin
    lines = {lcdRs, lcdRw, lcdDataOe, lcdDataOut};
    if (!rstN) begin
      chk(!hostReady && !lcdEn && !lcdRs, "R1", "outputs in reset",
          {hostReady, lcdEn, lcdRs}, 0);
      sinceRst = 0;
      run = 0;
      prevEn = 0;
      busy = 6;
    end else begin
      if (busy > 0) busy--;
      if (readyCd > 0) readyCd--;
      if (sinceRst < POWERUP)
        chk(!lcdEn && !lcdRs, "R1", "enable/rs during power-up", {lcdEn, lcdRs}, 0);
      if (lines != prevLines) begin
        if (lcdEn || prevEn || holdLeft > 0)
          chk(0, "R7", "bus lines moved inside strobe window", lines, prevLines);
        run = 0;
      end else run++;
      if (holdLeft > 0) holdLeft--;
      if (lcdEn && !prevEn) begin
        chk(run >= SETUP, "R7", "setup cycles before enable", run, SETUP);
        enHigh = 1;
      end else if (lcdEn) enHigh++;
      if (lcdEn) drvBusy = (lcdRw && (wide || !phase) && busy > 0);
      if (!lcdEn && prevEn) begin
        chk(enHigh == EN, "R7", "enable width", enHigh, EN);
        holdLeft = HOLD - 1;
        if (lcdRw) begin
          chk(!lcdRs && !lcdDataOe, "R4", "poll rs/oe", {lcdRs, lcdDataOe}, 0);
          if (wide || !phase) polledIdle = !drvBusy;
          if (!wide) phase = !phase;
        end else begin
          chk(lcdDataOe, "R4", "write drives bus", lcdDataOe, 1);
          done = 0;
          if (wide) begin
            got = lcdDataOut;
            done = 1;
          end else begin
            chk(lcdDataOut[3:0] == 4'h0, "R6", "low lines in nibble mode", lcdDataOut[3:0], 0);
            if (!phase) begin
              chk(busy == 0 && polledIdle, "R5", "write while busy or unpolled",
                  {busy != 0, polledIdle}, 1);
              hiNib = lcdDataOut[7:4];
              phase = 1;
            end else begin
              got = {hiNib, lcdDataOut[7:4]};
              phase = 0;
              done = 1;
            end
          end
          if (wide) chk(busy == 0 && polledIdle, "R5", "write while busy or unpolled",
                        {busy != 0, polledIdle}, 1);
          if (done) begin
            if (expQ.size() == 0) chk(0, "R3", "unexpected write", {lcdRs, got}, 0);
            else begin
              want = expQ.pop_front();
              chk({lcdRs, got} == want, (initLeft > 0) ? "R2" : "R3",
                  "written rs/byte", {lcdRs, got}, want);
              if (initLeft > 0) initLeft--;
            end
            if (wide && !lcdRs && got[7:5] == 3'b001 && !got[4]) wide = 0;
            nWrites++;
            busy = 2 + (nWrites * 7) % 13;
            polledIdle = 0;
            readyCd = HOLD;
          end
        end
      end
      expReady = (expQ.size() == 0) && (readyCd == 0);
      chk(hostReady == expReady, "R8", "hostReady", hostReady, expReady);
      if (hostValid && hostReady) expQ.push_back(hostWord);
      sinceRst++;
      prevEn = lcdEn;
    end
    prevLines = lines;
  end

endmodule

// File: tb/tb_lcd_seq_top.sv
`timescale 1ns/1ps
module tb_lcd_seq_top;

  logic clk = 0;
  logic rstN = 0;
  always #4 clk = ~clk;

  logic       v4 = 0, v8 = 0;
  logic [8:0] w4 = '0, w8 = '0;
  logic       r4, r8;
  logic [7:0] din4, din8, dout4, dout8;
  logic       oe4, oe8, rs4, rs8, rw4, rw8, en4, en8;

  int  tbCmp = 0;
  int  tbBad = 0;
  bit  finished = 0;

  lcd_seq_top #(.NIBBLE_MODE(1), .POWERUP_CYCLES(20), .SETUP_CYCLES(2), .EN_CYCLES(3),
                .HOLD_CYCLES(2), .TWO_LINES(1), .BIG_FONT(0), .DISP_ON(1),
                .CURSOR_ON(1), .BLINK_ON(0)) dut (
    .clk(clk), .rstN(rstN), .hostValid(v4), .hostWord(w4), .hostReady(r4),
    .lcdDataIn(din4), .lcdDataOut(dout4), .lcdDataOe(oe4), .lcdRs(rs4),
    .lcdRw(rw4), .lcdEn(en4));

  lcd_disp_model #(.NIB(1), .SETUP(2), .EN(3), .HOLD(2), .POWERUP(20), .TWO(1),
                   .BIG(0), .DON(1), .CON(1), .BON(0)) m4 (
    .clk(clk), .rstN(rstN), .hostValid(v4), .hostWord(w4), .hostReady(r4),
    .lcdDataOut(dout4), .lcdDataOe(oe4), .lcdRs(rs4), .lcdRw(rw4), .lcdEn(en4),
    .lcdDataIn(din4));

  lcd_seq_top #(.NIBBLE_MODE(0), .POWERUP_CYCLES(6), .SETUP_CYCLES(1), .EN_CYCLES(1),
                .HOLD_CYCLES(1), .TWO_LINES(0), .BIG_FONT(1), .DISP_ON(1),
                .CURSOR_ON(0), .BLINK_ON(1)) dut8 (
    .clk(clk), .rstN(rstN), .hostValid(v8), .hostWord(w8), .hostReady(r8),
    .lcdDataIn(din8), .lcdDataOut(dout8), .lcdDataOe(oe8), .lcdRs(rs8),
    .lcdRw(rw8), .lcdEn(en8));

  lcd_disp_model #(.NIB(0), .SETUP(1), .EN(1), .HOLD(1), .POWERUP(6), .TWO(0),
                   .BIG(1), .DON(1), .CON(0), .BON(1)) m8 (
    .clk(clk), .rstN(rstN), .hostValid(v8), .hostWord(w8), .hostReady(r8),
    .lcdDataOut(dout8), .lcdDataOe(oe8), .lcdRs(rs8), .lcdRw(rw8), .lcdEn(en8),
    .lcdDataIn(din8));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             tbCmp + m4.nCmp + m8.nCmp, tbBad + m4.nBad + m8.nBad);
  endtask

  task automatic send(input int sel, input logic [8:0] w);
    @(posedge clk); #1;
    if (sel == 0) begin v4 = 1; w4 = w; end
    else begin v8 = 1; w8 = w; end
    forever begin
      @(negedge clk);
      if ((sel == 0 && r4) || (sel == 1 && r8)) break;
    end
    @(posedge clk); #1;
    if (sel == 0) v4 = 0; else v8 = 0;
  endtask

  task automatic finalCheck(input int sel);
    forever begin
      @(negedge clk);
      if (sel == 0 && r4 && m4.expQ.size() == 0) break;
      if (sel == 1 && r8 && m8.expQ.size() == 0) break;
    end
    tbCmp++;
    if ((sel == 0 && !r4) || (sel == 1 && !r8)) begin
      tbBad++;
      $display("FAIL R8 final ready: actual 0 expected 1");
    end
  endtask

  logic [8:0] words [8] = '{9'h148, 9'h169, 9'h0C0, 9'h1FF, 9'h100, 9'h1A5, 9'h05A, 9'h101};

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1;
    // R1/R8: first word offered during initialization must wait
    for (int i = 0; i < 8; i++) begin
      send(0, words[i]);
      repeat (i % 3) @(posedge clk);
    end
    finalCheck(0);
    for (int i = 0; i < 8; i++) begin
      send(1, words[7 - i]);
      repeat ((i + 1) % 2) @(posedge clk);
    end
    finalCheck(1);
    repeat (10) @(posedge clk);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tbBad++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      summary();
      $finish;
    end
  end

endmodule